// File: doc/BRIEF.md
# Page-Mode Pseudo-Static RAM Controller

This block sits between an on-chip requester and an external asynchronous 16-bit pseudo-static RAM. The requester hands over single-word reads and writes through a valid/ready handshake. Each request carries a direction flag, a word address, write data and two byte-lane enables. Each completed read comes back as a one-cycle response pulse with its data. On the memory side the controller drives the active-low strobes (chip select, write strobe, output enable and one lane strobe per byte) and the address. It also owns the write direction of a shared three-state data bus.

Every access timing is a parameter counted in clock cycles, and one cycle of margin is added before each sample and each release. After the first read the controller leaves chip select low, which keeps a page of 2^PAGE_BITS words open. Later reads whose address differs only in the low PAGE_BITS bits then use the short in-page delay rather than the full random-access delay. The page closes on a read to another page, on any write, or before the running chip-select low time would exceed its upper bound. Writes are always standalone accesses. A minimum chip-select high recovery time separates any two accesses.

Top module: `psram_page_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both lane strobes are high, no response is pending, and the request interface shows ready.
- R2: A read that opens a new chip-select low period keeps the address and strobes steady for T_AA+1 cycles before sampling. When the read is accepted in the idle state, its response appears T_AA+1 clock edges after the accepting edge.
- R3: While a page is open, a read whose address matches the open page in all bits above PAGE_BITS keeps chip select low and is sampled after T_APA+1 cycles. Its response appears T_APA+1 edges after acceptance.
- R4: A read to a different page while a page is open raises chip select, waits out the recovery time and then performs a full access. Its response appears T_REC+1+T_AA+1 edges after acceptance.
- R5: Chip select never stays low for more than T_CEM consecutive cycles. When another page read would break that bound, the page is closed even during a run of page hits.
- R6: A write first closes any open page. It keeps chip select and write strobe low for T_WC+1 cycles, then raises them together with the lane strobes. Address and write data stay unchanged through the release cycle.
- R7: Request byte enable bit 0 selects the low byte [7:0] (lower lane strobe) and bit 1 the high byte [15:8] (upper lane strobe). A lane whose enable is 0 keeps its strobe high for the whole write, so the stored byte is left unchanged.
- R8: In a read response, a byte whose enable was 0 is returned as zero, whatever the memory drives on that lane.
- R9: The controller drives the data bus only for writes. The bus is released for at least one cycle before output enable goes low, and the write strobe and output enable are never low together.
- R10: Between two chip-select low periods, chip select stays high for at least T_REC+1 cycles.
- R11: Ready is high only in the idle state or while a page is open. It is low throughout a full read, a page read, a write and the recovery time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower byte lane strobe, active low |
| mem_ub_n | output | 1 | Upper byte lane strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | 16 | Three-state memory data bus |

## Verification
A wait counter that stops one cycle early makes the controller sample before the memory model's data is valid. The model drives a marker pattern until then, so the scoreboard sees wrong read data on that very response. A page tag or budget decision that goes wrong shows up in response latency that differs by whole recovery and access periods, in a count of chip-select falls that differs from the expected count, or in a chip-select low run that the model measures as too long. A broken write sequence shows up as a hold or duration violation in the model on the release edge, and as wrong data when the word is read back a few requests later.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES  = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACC,
      ST_PG_OPEN,
      ST_WR,
      ST_WR_REL,
      ST_RECOV
   } ctrl_state_e;

endpackage

// File: rtl/psram_page_tag.sv
module psram_page_tag #(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned PAGE_BITS = 4
) (
   input  logic              page_open,
   input  logic [ADDR_W-1:0] open_addr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              hit
);

   if (PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must be below ADDR_W");
   end

   if (PAGE_BITS == 0) begin : g_no_page
      logic unused_tag;
      assign unused_tag = ^{page_open, open_addr, req_addr, req_write};
      assign hit = 1'b0;
   end else begin : g_page
      assign hit = page_open && !req_write &&
                   (open_addr[ADDR_W-1:PAGE_BITS] == req_addr[ADDR_W-1:PAGE_BITS]);
   end

endmodule

// File: rtl/psram_ce_budget.sv
module psram_ce_budget #(
   parameter int unsigned T_CEM = 400,
   parameter int unsigned T_APA = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   output logic allow_hit
);

   localparam int unsigned RUN_W = $clog2(T_CEM + 1) + 1;
   localparam logic [RUN_W-1:0] CEM_L     = RUN_W'(T_CEM);
   localparam logic [RUN_W-1:0] HIT_LIMIT = RUN_W'(T_CEM - T_APA - 3);
   localparam logic [RUN_W-1:0] RUN_MAX   = '1;

   if (T_CEM < T_APA + 3) begin : g_bad_cem
      $error("T_CEM too small for a page read");
   end

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (ce_n) begin
         run_q <= '0;
      end else if (run_q != RUN_MAX) begin
         run_q <= run_q + 1'b1;
      end
   end

   // one more page read (open cycle, T_APA+1 access, next open cycle) fits
   assign allow_hit = (run_q <= HIT_LIMIT);

   // R5
   ce_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |-> (run_q < CEM_L));

endmodule

// File: rtl/psram_lane_io.sv
module psram_lane_io #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANES*LANE_W-1:0] dq_in,
   input  logic [LANES-1:0]        lane_n,
   output logic [LANES*LANE_W-1:0] rd_masked
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rd_masked[l*LANE_W +: LANE_W] =
         lane_n[l] ? '0 : dq_in[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
   import psram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned PAGE_BITS = 4,
   parameter int unsigned T_AA      = 7,
   parameter int unsigned T_APA     = 2,
   parameter int unsigned T_WC      = 7,
   parameter int unsigned T_REC     = 2,
   parameter int unsigned T_CEM     = 400
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [LANES*LANE_W-1:0]  req_wdata,
   input  logic [LANES-1:0]         req_be,
   output logic                     rsp_valid,
   output logic [LANES*LANE_W-1:0]  rsp_rdata,
   output logic                     mem_ce_n,
   output logic                     mem_we_n,
   output logic                     mem_oe_n,
   output logic                     mem_lb_n,
   output logic                     mem_ub_n,
   output logic [ADDR_W-1:0]        mem_addr,
   inout  wire  [LANES*LANE_W-1:0]  mem_dq
);

   localparam int unsigned DATA_W = LANES * LANE_W;
   localparam int unsigned MAX1   = (T_AA > T_WC) ? T_AA : T_WC;
   localparam int unsigned MAXT   = (MAX1 > T_REC) ? MAX1 : T_REC;
   localparam int unsigned CNT_W  = $clog2(MAXT + 1);
   localparam logic [CNT_W-1:0] C_AA  = CNT_W'(T_AA);
   localparam logic [CNT_W-1:0] C_APA = CNT_W'(T_APA);
   localparam logic [CNT_W-1:0] C_WC  = CNT_W'(T_WC);
   localparam logic [CNT_W-1:0] C_REC = CNT_W'(T_REC);

   if (T_APA < 1 || T_APA >= T_AA) begin : g_bad_apa
      $error("T_APA must be at least 1 and below T_AA");
   end
   if (T_WC < 1) begin : g_bad_wc
      $error("T_WC must be at least 1");
   end
   if (T_CEM < T_AA + 2) begin : g_bad_cem
      $error("T_CEM must cover a full read plus one open cycle");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("controller has one lower and one upper lane strobe");
   end

   ctrl_state_e         state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                ce_n_q, we_n_q, oe_n_q, dq_oe_q;
   logic [LANES-1:0]    lane_n_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q, rdata_q;
   logic                rsp_v_q;

   logic                pend_q, pend_wr_q;
   logic [ADDR_W-1:0]   pend_addr_q;
   logic [DATA_W-1:0]   pend_wdata_q;
   logic [LANES-1:0]    pend_be_q;

   logic                hit, allow_hit, accept;
   logic [DATA_W-1:0]   rd_masked;

   logic                st_go, st_wr;
   logic [ADDR_W-1:0]   st_addr;
   logic [DATA_W-1:0]   st_wdata;
   logic [LANES-1:0]    st_be;

   psram_page_tag #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_tag (
      .page_open (state_q == ST_PG_OPEN),
      .open_addr (addr_q),
      .req_addr  (req_addr),
      .req_write (req_write),
      .hit       (hit)
   );

   psram_ce_budget #(.T_CEM(T_CEM), .T_APA(T_APA)) u_budget (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n_q),
      .allow_hit (allow_hit)
   );

   psram_lane_io #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .dq_in     (mem_dq),
      .lane_n    (lane_n_q),
      .rd_masked (rd_masked)
   );

   always_comb begin
      case (state_q)
         ST_IDLE:    req_ready = 1'b1;
         ST_PG_OPEN: req_ready = allow_hit;
         default:    req_ready = 1'b0;
      endcase
   end

   assign accept = req_valid && req_ready;

   // source of a fresh access: a request taken in idle, or the one held across recovery
   always_comb begin
      st_go    = 1'b0;
      st_wr    = req_write;
      st_addr  = req_addr;
      st_wdata = req_wdata;
      st_be    = req_be;
      if (state_q == ST_IDLE && accept) begin
         st_go = 1'b1;
      end else if (state_q == ST_RECOV && cnt_q == '0 && pend_q) begin
         st_go    = 1'b1;
         st_wr    = pend_wr_q;
         st_addr  = pend_addr_q;
         st_wdata = pend_wdata_q;
         st_be    = pend_be_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cnt_q        <= '0;
         ce_n_q       <= 1'b1;
         we_n_q       <= 1'b1;
         oe_n_q       <= 1'b1;
         dq_oe_q      <= 1'b0;
         lane_n_q     <= '1;
         addr_q       <= '0;
         wdata_q      <= '0;
         rdata_q      <= '0;
         rsp_v_q      <= 1'b0;
         pend_q       <= 1'b0;
         pend_wr_q    <= 1'b0;
         pend_addr_q  <= '0;
         pend_wdata_q <= '0;
         pend_be_q    <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         if (st_go) begin
            addr_q   <= st_addr;
            lane_n_q <= ~st_be;
            ce_n_q   <= 1'b0;
            pend_q   <= 1'b0;
            if (st_wr) begin
               state_q <= ST_WR;
               cnt_q   <= C_WC;
               we_n_q  <= 1'b0;
               oe_n_q  <= 1'b1;
               dq_oe_q <= 1'b1;
               wdata_q <= st_wdata;
            end else begin
               state_q <= ST_RD_ACC;
               cnt_q   <= C_AA;
               we_n_q  <= 1'b1;
               oe_n_q  <= 1'b0;
               dq_oe_q <= 1'b0;
            end
         end else begin
            case (state_q)
               ST_RD_ACC: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else begin
                     rdata_q <= rd_masked;
                     rsp_v_q <= 1'b1;
                     state_q <= ST_PG_OPEN;
                  end
               end
               ST_PG_OPEN: begin
                  if (!allow_hit || (req_valid && !hit)) begin
                     if (allow_hit) begin
                        pend_q       <= 1'b1;
                        pend_wr_q    <= req_write;
                        pend_addr_q  <= req_addr;
                        pend_wdata_q <= req_wdata;
                        pend_be_q    <= req_be;
                     end
                     state_q  <= ST_RECOV;
                     cnt_q    <= C_REC;
                     ce_n_q   <= 1'b1;
                     oe_n_q   <= 1'b1;
                     lane_n_q <= '1;
                  end else if (req_valid) begin
                     addr_q   <= req_addr;
                     lane_n_q <= ~req_be;
                     cnt_q    <= C_APA;
                     state_q  <= ST_RD_ACC;
                  end
               end
               ST_WR: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else begin
                     state_q  <= ST_WR_REL;
                     ce_n_q   <= 1'b1;
                     we_n_q   <= 1'b1;
                     lane_n_q <= '1;
                  end
               end
               ST_WR_REL: begin
                  state_q <= ST_RECOV;
                  dq_oe_q <= 1'b0;
                  cnt_q   <= C_REC;
               end
               ST_RECOV: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign mem_dq    = dq_oe_q ? wdata_q : {DATA_W{1'bz}};
   assign mem_ce_n  = ce_n_q;
   assign mem_we_n  = we_n_q;
   assign mem_oe_n  = oe_n_q;
   assign mem_lb_n  = lane_n_q[0];
   assign mem_ub_n  = lane_n_q[1];
   assign mem_addr  = addr_q;
   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rdata_q;

   // R9
   dq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_q |-> (!dq_oe_q && !$past(dq_oe_q)));

   // R9
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_q |-> (oe_n_q && dq_oe_q));

   // R6
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n_q) |-> (dq_oe_q && $stable(addr_q) && $stable(wdata_q)));

   // R2
   rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_v_q |-> $past(!ce_n_q && !oe_n_q));

   // R11
   accept_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (ce_n_q || (!oe_n_q && we_n_q)));

endmodule

// File: tb/psram_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_page_ctrl_tb_top;

   localparam int AW    = 8;
   localparam int T_AA  = 6;
   localparam int T_APA = 2;
   localparam int T_WC  = 4;
   localparam int T_REC = 2;
   localparam int T_CEM = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          req_ready, rsp_valid;
   logic [15:0]   rsp_rdata;
   logic          mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
   logic [AW-1:0] mem_addr;
   wire  [15:0]   mem_dq;

   psram_page_ctrl #(.ADDR_W(AW), .PAGE_BITS(4), .T_AA(T_AA), .T_APA(T_APA),
                     .T_WC(T_WC), .T_REC(T_REC), .T_CEM(T_CEM)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
      .mem_dq(mem_dq));

   int vec = 0;
   int errs = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      vec++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] seed(input int i);
      return 16'(i * 257) ^ 16'h5A3C;
   endfunction

   // ---------------- memory model ----------------
   logic [15:0] mem_arr [256];
   logic [15:0] shadow  [256];
   initial for (int i = 0; i < 256; i++) begin
      mem_arr[i] = seed(i);
      shadow[i]  = seed(i);
   end

   logic [AW-1:0] last_addr = '0;
   logic          pg_v = 1'b0;
   int            rcnt = 0, need = T_AA;
   logic [15:0]   drv;
   logic          rd_ok;

   always_comb begin
      rd_ok = pg_v && (mem_addr == last_addr) && (rcnt >= need);
      drv[7:0]  = !mem_lb_n ? (rd_ok ? mem_arr[mem_addr][7:0]  : 8'hDE) : 8'hA5;
      drv[15:8] = !mem_ub_n ? (rd_ok ? mem_arr[mem_addr][15:8] : 8'hAD) : 8'hA5;
   end
   assign mem_dq = (!mem_ce_n && !mem_oe_n) ? drv : 16'hzzzz;

   always @(posedge clk) begin
      if (mem_ce_n || mem_oe_n) begin
         pg_v <= 1'b0;
         rcnt <= 0;
      end else begin
         last_addr <= mem_addr;
         if (!pg_v || mem_addr[AW-1:4] != last_addr[AW-1:4]) begin
            need <= T_AA; rcnt <= 1; pg_v <= 1'b1;
         end else if (mem_addr != last_addr) begin
            need <= T_APA; rcnt <= 1;
         end else if (rcnt < 1000) begin
            rcnt <= rcnt + 1;
         end
      end
   end

   // write capture, chip-select run and gap checks
   int            wcnt = 0;
   logic [AW-1:0] w_addr;
   logic [15:0]   w_data;
   logic          w_lb, w_ub;
   int            lo_cnt = 0, hi_cnt = 1000, ce_falls = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         // R9: write strobe and output enable never low together
         chk(!(!mem_we_n && !mem_oe_n), "R9 we/oe overlap", {mem_we_n, mem_oe_n}, 2'b11);
         if (!mem_ce_n && !mem_we_n) begin
            if (wcnt == 0) begin
               w_addr = mem_addr; w_data = mem_dq;
               w_lb = !mem_lb_n; w_ub = !mem_ub_n;
            end else begin
               chk(mem_addr == w_addr && mem_dq == w_data, "R6 write data moved",
                   {mem_addr, mem_dq}, {w_addr, w_data});
               chk({!mem_ub_n, !mem_lb_n} == {w_ub, w_lb}, "R7 lane strobe moved",
                   {!mem_ub_n, !mem_lb_n}, {w_ub, w_lb});
            end
            wcnt++;
         end else if (wcnt != 0) begin
            chk(mem_addr == w_addr && mem_dq == w_data, "R6 release hold",
                {mem_addr, mem_dq}, {w_addr, w_data});
            chk(wcnt >= T_WC + 1, "R6 write length", wcnt, T_WC + 1);
            if (w_lb) mem_arr[w_addr][7:0]  = w_data[7:0];
            if (w_ub) mem_arr[w_addr][15:8] = w_data[15:8];
            wcnt = 0;
         end
         if (!mem_ce_n) begin
            if (hi_cnt > 0) begin
               chk(hi_cnt >= T_REC + 1, "R10 chip select gap", hi_cnt, T_REC + 1);
               ce_falls++;
               lo_cnt = 0;
            end
            hi_cnt = 0;
            lo_cnt++;
         end else begin
            if (lo_cnt > 0) chk(lo_cnt <= T_CEM, "R5 chip select low run", lo_cnt, T_CEM);
            lo_cnt = 0;
            hi_cnt++;
         end
      end
   end

   always @(posedge clk) cyc++;

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [15:0] data;
      int          lat;
      int          acc;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R2 unexpected response", rsp_rdata, 0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(rsp_rdata == e.data, {e.tag, " read data"}, rsp_rdata, e.data);
            if (e.lat != 0)
               chk(cyc - e.acc == e.lat, {e.tag, " latency"}, cyc - e.acc, e.lat);
         end
      end
   end

   function automatic logic [15:0] masked(input logic [15:0] w, input logic [1:0] be);
      return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
   endfunction

   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int lat, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      if (wr) begin
         if (be[0]) shadow[a][7:0]  = d[7:0];
         if (be[1]) shadow[a][15:8] = d[15:8];
      end else begin
         exp_t e;
         e.data = masked(shadow[a], be); e.lat = lat; e.acc = cyc + 1; e.tag = tag;
         sbq.push_back(e);
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic drain();
      while (sbq.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int f0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111,
          "R1 strobes after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
      chk(!rsp_valid, "R1 no response after reset", rsp_valid, 0);
      chk(req_ready, "R1 ready after reset", req_ready, 1);

      // R2 full read from idle, then R3 page hits on one chip-select period
      f0 = ce_falls;
      issue(0, 8'h10, 0, 2'b11, T_AA + 1, "R2");
      issue(0, 8'h13, 0, 2'b11, T_APA + 1, "R3");
      issue(0, 8'h11, 0, 2'b11, T_APA + 1, "R3");
      issue(0, 8'h1F, 0, 2'b11, T_APA + 1, "R3");
      drain();
      chk(ce_falls - f0 == 1, "R3 single chip-select period", ce_falls - f0, 1);

      // R4 page miss
      repeat (40) @(negedge clk);
      f0 = ce_falls;
      issue(0, 8'h20, 0, 2'b11, T_AA + 1, "R2");
      issue(0, 8'h35, 0, 2'b11, T_REC + 1 + T_AA + 1, "R4");
      issue(0, 8'h36, 0, 2'b11, T_APA + 1, "R3");
      drain();
      chk(ce_falls - f0 == 2, "R4 miss reopens chip select", ce_falls - f0, 2);

      // R5 budget closes a long run of page hits
      repeat (40) @(negedge clk);
      f0 = ce_falls;
      for (int i = 0; i < 8; i++) issue(0, 8'(8'h40 + i), 0, 2'b11, 0, "R5");
      drain();
      chk(ce_falls - f0 == 2, "R5 budget split", ce_falls - f0, 2);

      // R6/R7 writes with each byte-enable pattern
      repeat (40) @(negedge clk);
      issue(1, 8'h60, 16'h1234, 2'b11, 0, "R6");
      @(negedge clk);
      chk(!req_ready, "R11 ready low during write", req_ready, 0);
      issue(1, 8'h61, 16'hBEEF, 2'b01, 0, "R7");
      issue(1, 8'h62, 16'hCAFE, 2'b10, 0, "R7");
      issue(1, 8'h63, 16'h7777, 2'b00, 0, "R7");
      issue(0, 8'h60, 0, 2'b11, 0, "R6");
      issue(0, 8'h61, 0, 2'b11, 0, "R7");
      issue(0, 8'h62, 0, 2'b11, 0, "R7");
      issue(0, 8'h63, 0, 2'b11, 0, "R7");
      drain();

      // R6 write issued while a page is open
      repeat (40) @(negedge clk);
      issue(0, 8'h70, 0, 2'b11, T_AA + 1, "R2");
      issue(1, 8'h71, 16'h4242, 2'b11, 0, "R6");
      issue(0, 8'h71, 0, 2'b11, 0, "R6");
      issue(0, 8'h70, 0, 2'b11, T_APA + 1, "R3");
      drain();

      // R8 disabled read lanes return zero
      repeat (40) @(negedge clk);
      issue(0, 8'h12, 0, 2'b01, T_AA + 1, "R8");
      issue(0, 8'h14, 0, 2'b10, T_APA + 1, "R8");
      issue(0, 8'h15, 0, 2'b00, T_APA + 1, "R8");
      drain();

      chk(sbq.size() == 0, "R2 responses outstanding", sbq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired R11 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
   end

endmodule